// File: doc/BRIEF.md
# Address-Space-Tagged Virtual Data Cache

This block is a small direct-mapped data cache that is both indexed and tagged with virtual addresses. Every stored line carries, next to its virtual tag, the 8-bit address space identifier (ASID) of the process whose read brought it in. A lookup succeeds only when the tag and the identifier both agree. The same virtual address used by two processes therefore never returns the other process's data. A line can also be marked global when it is filled, and a global line matches any identifier. This suits regions that are mapped identically in every address space.

Stores are written through to a physically addressed backing store. A store also updates the cached word when it hits, and a store that misses allocates nothing. A read miss issues one whole-line read, installs the line and returns the requested word. Before an identifier is handed to a new address space, a flush command sweeps every set, one set per clock. The sweep drops the non-global lines that carry that identifier. While the sweep runs the block reports busy and accepts no requests. Address translation, coherence and writable synonyms are left to the surrounding system, and the backing store is addressed with the request address as given.

The geometry is 64 sets of 16-byte lines with 32-bit words and 32-bit addresses. Byte offset is address bits [3:0], the word within a line is bits [3:2], the set index is bits [9:4] and the tag is bits [31:10].

Top module: `vcache_asid`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `busy`, `rsp_valid` and `mem_req_valid` are 0, so the first read of any address misses.
- R2: A read miss raises `mem_req_valid` with `mem_req_write`=0 and `mem_req_addr` equal to the request address with bits [3:0] cleared, in the cycle after acceptance. The cycle after `mem_rvalid` is seen, `rsp_valid` is 1 and `rsp_rdata` is word k of `mem_rline` (bits 32k+31..32k, k = address bits [3:2]).
- R3: A read whose set holds a valid line with equal tag and equal ASID returns the word with `rsp_valid`=1 in the cycle after acceptance and issues no backing-store request.
- R4: A non-global line filled under one ASID does not hit for a request carrying a different ASID, even at the same virtual address.
- R5: A line filled by a read with `req_global`=1 hits for requests under any ASID.
- R6: Every accepted write produces, in the cycle after acceptance, `mem_req_valid`=1 and `mem_req_write`=1 with the full request address and data, together with `rsp_valid`=1 and `rsp_rdata`=0.
- R7: A write hit updates the cached word so that later hits return the new value. A write miss installs no line, so the next read of that address misses.
- R8: `flush_valid` taken while idle has priority over a request in the same cycle, and `busy` then stays 1 for exactly 64 cycles starting the cycle after. `req_ready` is 0 for that whole time and no request is accepted.
- R9: A flush invalidates exactly the non-global lines whose ASID equals `flush_asid`. Lines of other identifiers and global lines keep hitting.
- R10: Filling a set replaces its previous line, so an address with a different tag in the same set misses afterwards.
- R11: From acceptance of a read miss until its response, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_global | input | 1 | Mark a line filled by this load as global |
| req_asid | input | 8 | Address space identifier of the requester |
| req_addr | input | 32 | Virtual byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| flush_valid | input | 1 | Start an identifier sweep (held until busy rises) |
| flush_asid | input | 8 | Identifier to purge |
| busy | output | 1 | Sweep in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Load data, zero for store acknowledges |
| mem_req_valid | output | 1 | Backing-store request strobe |
| mem_req_write | output | 1 | 1 = word store, 0 = line read |
| mem_req_addr | output | 32 | Backing-store byte address |
| mem_req_wdata | output | 32 | Backing-store store data |
| mem_rvalid | input | 1 | Line read data present |
| mem_rline | input | 128 | Line read data, word 0 in the low bits |

## Verification
Loads are issued to one virtual address under the filling identifier, under a different identifier and again under the first. This separates a tag-only match from a tag-and-identifier match and shows that a refill retags the set. Reads of several words of one line check word selection on both the fill path and the hit path. A global line read back under unrelated identifiers shows that the global bit bypasses the identifier compare. A sweep that targets the global line's own identifier, with lines of a second identifier alongside, shows the sweep is selective. Stores to a resident line and to an absent line show the write-through and no-allocate behaviour, and a same-set, different-tag read shows replacement.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

    localparam int VC_ADDR_W     = 32;
    localparam int VC_DATA_W     = 32;
    localparam int VC_ASID_W     = 8;
    localparam int VC_SETS       = 64;
    localparam int VC_LINE_BYTES = 16;

    localparam int VC_WORDS  = VC_LINE_BYTES / (VC_DATA_W / 8);
    localparam int VC_OFF_W  = $clog2(VC_LINE_BYTES);
    localparam int VC_BYTE_W = $clog2(VC_DATA_W / 8);
    localparam int VC_WSEL_W = $clog2(VC_WORDS);
    localparam int VC_IDX_W  = $clog2(VC_SETS);
    localparam int VC_TAG_W  = VC_ADDR_W - VC_IDX_W - VC_OFF_W;
    localparam int VC_LINE_W = VC_WORDS * VC_DATA_W;

    typedef logic [VC_ADDR_W-1:0] addr_t;
    typedef logic [VC_DATA_W-1:0] word_t;
    typedef logic [VC_LINE_W-1:0] line_t;
    typedef logic [VC_ASID_W-1:0] asid_t;
    typedef logic [VC_IDX_W-1:0]  idx_t;
    typedef logic [VC_TAG_W-1:0]  tag_t;
    typedef logic [VC_WSEL_W-1:0] wsel_t;

    typedef struct packed {
        logic  valid;
        logic  glob;
        asid_t asid;
        tag_t  tag;
    } meta_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctl_st_e;

    function automatic idx_t idx_of(addr_t a);
        return a[VC_OFF_W +: VC_IDX_W];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[VC_ADDR_W-1 -: VC_TAG_W];
    endfunction

    function automatic wsel_t wsel_of(addr_t a);
        return a[VC_BYTE_W +: VC_WSEL_W];
    endfunction

    function automatic addr_t line_base(addr_t a);
        return {a[VC_ADDR_W-1:VC_OFF_W], {VC_OFF_W{1'b0}}};
    endfunction

    function automatic word_t pick_word(line_t l, wsel_t s);
        return l[s*VC_DATA_W +: VC_DATA_W];
    endfunction

endpackage

// File: rtl/vca_line_store.sv
module vca_line_store
    import vcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  lk_idx,
    output meta_t lk_meta,
    output line_t lk_line,
    input  idx_t  fl_idx,
    output logic  fl_valid,
    output logic  fl_glob,
    output asid_t fl_asid,
    input  logic  fill_en,
    input  idx_t  fill_idx,
    input  meta_t fill_meta,
    input  line_t fill_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  wsel_t wr_sel,
    input  word_t wr_data,
    input  logic  inv_en,
    input  idx_t  inv_idx
);

    meta_t meta_q [VC_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VC_SETS; i++) begin
                meta_q[i].valid <= 1'b0;
            end
        end else begin
            if (fill_en) begin
                meta_q[fill_idx] <= fill_meta;
            end
            if (inv_en) begin
                meta_q[inv_idx].valid <= 1'b0;
            end
        end
    end

    assign lk_meta  = meta_q[lk_idx];
    assign fl_valid = meta_q[fl_idx].valid;
    assign fl_glob  = meta_q[fl_idx].glob;
    assign fl_asid  = meta_q[fl_idx].asid;

    // One storage bank per word of the line.
    for (genvar w = 0; w < VC_WORDS; w++) begin : g_bank
        word_t bank_q [VC_SETS];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                bank_q[fill_idx] <= fill_line[w*VC_DATA_W +: VC_DATA_W];
            end else if (wr_en && (wr_sel == wsel_t'(w))) begin
                bank_q[wr_idx] <= wr_data;
            end
        end

        assign lk_line[w*VC_DATA_W +: VC_DATA_W] = bank_q[lk_idx];
    end

    // A fill and a sweep invalidation never meet: requests stall during the sweep.
    p_fill_sweep_apart_r8: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && inv_en));

endmodule

// File: rtl/vca_tag_match.sv
module vca_tag_match
    import vcache_pkg::*;
(
    input  meta_t ent,
    input  tag_t  tag,
    input  asid_t asid,
    output logic  hit
);

    logic tag_eq;
    logic space_ok;

    assign tag_eq   = (ent.tag == tag);
    assign space_ok = ent.glob || (ent.asid == asid);
    assign hit      = ent.valid && tag_eq && space_ok;

endmodule

// File: rtl/vca_asid_sweep.sv
module vca_asid_sweep
    import vcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  asid_t start_asid,
    input  logic  ent_valid,
    input  logic  ent_glob,
    input  asid_t ent_asid,
    output logic  active,
    output idx_t  idx,
    output logic  inv_en
);

    localparam idx_t LAST_IDX = idx_t'(VC_SETS - 1);

    asid_t victim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            victim_q <= '0;
        end else if (start && !active) begin
            active   <= 1'b1;
            idx      <= '0;
            victim_q <= start_asid;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) begin
                active <= 1'b0;
            end
        end
    end

    assign inv_en = active && ent_valid && !ent_glob && (ent_asid == victim_q);

    p_sweep_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (active && idx == LAST_IDX) |=> !active);

    p_sweep_steps_r8: assert property (@(posedge clk) disable iff (rst)
        (active && idx != LAST_IDX) |=> (active && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/vcache_asid.sv
module vcache_asid
    import vcache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_global,
    input  logic [VC_ASID_W-1:0] req_asid,
    input  logic [VC_ADDR_W-1:0] req_addr,
    input  logic [VC_DATA_W-1:0] req_wdata,
    input  logic                 flush_valid,
    input  logic [VC_ASID_W-1:0] flush_asid,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [VC_DATA_W-1:0] rsp_rdata,
    output logic                 mem_req_valid,
    output logic                 mem_req_write,
    output logic [VC_ADDR_W-1:0] mem_req_addr,
    output logic [VC_DATA_W-1:0] mem_req_wdata,
    input  logic                 mem_rvalid,
    input  logic [VC_LINE_W-1:0] mem_rline
);

    ctl_st_e state_q;
    idx_t    pend_idx_q;
    tag_t    pend_tag_q;
    wsel_t   pend_wsel_q;
    asid_t   pend_asid_q;
    logic    pend_glob_q;

    meta_t lk_meta;
    line_t lk_line;
    logic  hit;
    logic  accept;
    logic  sweep_start;
    logic  sweep_active;
    idx_t  sweep_idx;
    logic  sweep_inv;
    logic  fl_valid;
    logic  fl_glob;
    asid_t fl_asid;
    logic  fill_en;
    meta_t fill_meta;
    logic  wr_hit;

    assign sweep_start = flush_valid && (state_q == ST_IDLE) && !sweep_active;
    assign req_ready   = (state_q == ST_IDLE) && !sweep_active && !flush_valid;
    assign accept      = req_valid && req_ready;
    assign busy        = sweep_active;

    assign wr_hit  = accept && req_write && hit;
    assign fill_en = (state_q == ST_FILL) && mem_rvalid;

    always_comb begin
        fill_meta       = '0;
        fill_meta.valid = 1'b1;
        fill_meta.glob  = pend_glob_q;
        fill_meta.asid  = pend_asid_q;
        fill_meta.tag   = pend_tag_q;
    end

    vca_line_store u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (idx_of(req_addr)),
        .lk_meta   (lk_meta),
        .lk_line   (lk_line),
        .fl_idx    (sweep_idx),
        .fl_valid  (fl_valid),
        .fl_glob   (fl_glob),
        .fl_asid   (fl_asid),
        .fill_en   (fill_en),
        .fill_idx  (pend_idx_q),
        .fill_meta (fill_meta),
        .fill_line (mem_rline),
        .wr_en     (wr_hit),
        .wr_idx    (idx_of(req_addr)),
        .wr_sel    (wsel_of(req_addr)),
        .wr_data   (req_wdata),
        .inv_en    (sweep_inv),
        .inv_idx   (sweep_idx)
    );

    vca_tag_match u_match (
        .ent  (lk_meta),
        .tag  (tag_of(req_addr)),
        .asid (req_asid),
        .hit  (hit)
    );

    vca_asid_sweep u_sweep (
        .clk        (clk),
        .rst        (rst),
        .start      (sweep_start),
        .start_asid (flush_asid),
        .ent_valid  (fl_valid),
        .ent_glob   (fl_glob),
        .ent_asid   (fl_asid),
        .active     (sweep_active),
        .idx        (sweep_idx),
        .inv_en     (sweep_inv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            pend_idx_q    <= '0;
            pend_tag_q    <= '0;
            pend_wsel_q   <= '0;
            pend_asid_q   <= '0;
            pend_glob_q   <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_write) begin
                            mem_req_valid <= 1'b1;
                            mem_req_write <= 1'b1;
                            mem_req_addr  <= req_addr;
                            mem_req_wdata <= req_wdata;
                            rsp_valid     <= 1'b1;
                            rsp_rdata     <= '0;
                        end else if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= pick_word(lk_line, wsel_of(req_addr));
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_write <= 1'b0;
                            mem_req_addr  <= line_base(req_addr);
                            mem_req_wdata <= '0;
                            pend_idx_q    <= idx_of(req_addr);
                            pend_tag_q    <= tag_of(req_addr);
                            pend_wsel_q   <= wsel_of(req_addr);
                            pend_asid_q   <= req_asid;
                            pend_glob_q   <= req_global;
                            state_q       <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rvalid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= pick_word(mem_rline, pend_wsel_q);
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_line_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !hit) |=> (mem_req_valid && !mem_req_write && state_q == ST_FILL));

    p_fill_answers_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_rvalid) |=> (rsp_valid && state_q == ST_IDLE));

    p_hit_local_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && hit) |=> (rsp_valid && !mem_req_valid));

    p_store_through_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write) |=> (mem_req_valid && mem_req_write && rsp_valid));

    p_sweep_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    p_miss_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> !req_ready);

endmodule

// File: tb/vcache_asid_bench.sv
module vcache_asid_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic         req_global = 1'b0;
    logic [7:0]   req_asid = '0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         flush_valid = 1'b0;
    logic [7:0]   flush_asid = '0;
    logic         busy;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_req_valid;
    logic         mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [31:0]  mem_req_wdata;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rline = '0;

    int n_run  = 0;
    int n_fail = 0;

    // Behavioural reference: per-set records plus a sparse backing store.
    bit          m_valid [64];
    logic [21:0] m_tag   [64];
    logic [7:0]  m_asid  [64];
    bit          m_glob  [64];
    logic [31:0] bstore  [int];

    always #4 clk = ~clk;

    vcache_asid u_vcache_asid (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_global    (req_global),
        .req_asid      (req_asid),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .flush_valid   (flush_valid),
        .flush_asid    (flush_asid),
        .busy          (busy),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rvalid    (mem_rvalid),
        .mem_rline     (mem_rline)
    );

    function automatic int set_of(logic [31:0] a);
        return int'((a >> 4) & 32'd63);
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        int key = int'(a >> 2);
        if (bstore.exists(key)) return bstore[key];
        return {a[31:2], 2'b00} ^ 32'h5A3C_0F00;
    endfunction

    function automatic bit model_hit(logic [31:0] a, logic [7:0] asid);
        int s = set_of(a);
        return m_valid[s] && (m_tag[s] == a[31:10]) && (m_glob[s] || m_asid[s] == asid);
    endfunction

    task automatic chk(input string rq, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic [7:0] asid, input bit glob, input string rq);
        bit exp_hit = model_hit(a, asid);
        logic [31:0] base = {a[31:4], 4'h0};
        logic [127:0] line;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_asid = asid; req_global = glob;
        #1 chk(rq, "ready before read", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(rq, "hit strobe", rsp_valid, 1);
            chk(rq, "hit makes no store access", mem_req_valid, 0);
            chk(rq, "hit data", rsp_rdata, mem_word(a));
        end else begin
            chk(rq, "no early response on miss", rsp_valid, 0);
            chk(rq, "line read strobe", mem_req_valid, 1);
            chk(rq, "line read is a read", mem_req_write, 0);
            chk(rq, "line read address", mem_req_addr, base);
            @(negedge clk);
            chk("R11", "ready low while miss pending", req_ready, 0);
            for (int w = 0; w < 4; w++) line[w*32 +: 32] = mem_word(base + 32'(4*w));
            mem_rvalid = 1'b1; mem_rline = line;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk(rq, "fill response strobe", rsp_valid, 1);
            chk(rq, "fill response data", rsp_rdata, mem_word(a));
            m_valid[set_of(a)] = 1'b1;
            m_tag[set_of(a)]   = a[31:10];
            m_asid[set_of(a)]  = asid;
            m_glob[set_of(a)]  = glob;
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [7:0] asid, input logic [31:0] d, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_asid = asid; req_wdata = d; req_global = 1'b0;
        #1 chk(rq, "ready before write", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R6", "store strobe", mem_req_valid, 1);
        chk("R6", "store is a write", mem_req_write, 1);
        chk("R6", "store address", mem_req_addr, a);
        chk("R6", "store data", mem_req_wdata, d);
        chk("R6", "store acknowledge", rsp_valid, 1);
        chk("R6", "store acknowledge data", rsp_rdata, 0);
        bstore[int'(a >> 2)] = d;
    endtask

    task automatic do_flush(input logic [7:0] asid);
        @(negedge clk);
        flush_valid = 1'b1; flush_asid = asid;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0040; req_asid = asid;
        #1 chk("R8", "flush wins over request", req_ready, 0);
        @(negedge clk);
        flush_valid = 1'b0;
        for (int i = 0; i < 64; i++) begin
            chk("R8", "busy during sweep", busy, 1);
            chk("R8", "ready low during sweep", req_ready, 0);
            chk("R8", "no response during sweep", rsp_valid, 0);
            chk("R8", "no store access during sweep", mem_req_valid, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8", "busy ends after 64 cycles", busy, 0);
        chk("R8", "ready returns after sweep", req_ready, 1);
        for (int s = 0; s < 64; s++)
            if (m_valid[s] && !m_glob[s] && m_asid[s] == asid) m_valid[s] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 64; s++) m_valid[s] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "no response after reset", rsp_valid, 0);
        chk("R1", "no store access after reset", mem_req_valid, 0);

        // R1, R2: cold miss, word 1 of the line
        do_read(32'h0000_1234, 8'd5, 1'b0, "R2");
        // R3: hits on several words of the resident line
        do_read(32'h0000_1234, 8'd5, 1'b0, "R3");
        do_read(32'h0000_1238, 8'd5, 1'b0, "R3");
        do_read(32'h0000_123C, 8'd5, 1'b0, "R3");
        do_read(32'h0000_1230, 8'd5, 1'b0, "R3");
        // R4: same virtual address under other identifiers misses
        do_read(32'h0000_1234, 8'd6, 1'b0, "R4");
        do_read(32'h0000_1234, 8'd5, 1'b0, "R4");
        // R7: write hit then read-back hit
        do_write(32'h0000_1234, 8'd5, 32'hDEAD_BEEF, "R7");
        do_read(32'h0000_1234, 8'd5, 1'b0, "R7");
        // R7: write miss does not allocate
        do_write(32'h0000_8000, 8'd2, 32'h1234_5678, "R7");
        do_read(32'h0000_8000, 8'd2, 1'b0, "R7");
        // R10: same set, different tag replaces
        do_read(32'h0000_1634, 8'd5, 1'b0, "R10");
        do_read(32'h0000_1234, 8'd5, 1'b0, "R10");
        // R5: global line hits for any identifier
        do_read(32'h0000_4560, 8'd3, 1'b1, "R5");
        do_read(32'h0000_4564, 8'd9, 1'b0, "R5");
        do_read(32'h0000_4568, 8'd200, 1'b0, "R5");
        // R9: populate, sweep identifier 3, probe survivors
        do_read(32'h0000_2040, 8'd3, 1'b0, "R9");
        do_read(32'h0000_20F8, 8'd3, 1'b0, "R9");
        do_read(32'h0000_3050, 8'd4, 1'b0, "R9");
        do_flush(8'd3);
        do_read(32'h0000_2040, 8'd3, 1'b0, "R9");
        do_read(32'h0000_3050, 8'd4, 1'b0, "R9");
        do_read(32'h0000_456C, 8'd3, 1'b0, "R9");
        do_read(32'h0000_20F8, 8'd3, 1'b0, "R9");
        do_read(32'h0000_1234, 8'd5, 1'b0, "R9");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule